// File: doc/BRIEF.md
# Dual Command/Data Push FIFO Front-End

This block is the master-side write path of a serial peripheral controller. A single 32-bit push port feeds two 4-entry queues: a 16-bit command queue on bits 31:16 and a 16-bit transmit-data queue on bits 15:0. The shift engine drains both queues through valid/ready pop ports. Reading the push port returns the two queue heads side by side. While the block is off, it returns the last value written while it was on.

A registered mode state machine sets how writes are decoded. It has four states: `M_OFF` (block disabled), `M_LOCK` (master, lockstep pushes, the two queues act as one 32-bit queue), `M_EXT` (master, the queues are pushed and popped independently) and `M_SLAVE` (the command queue is unused). Every cycle the next state is chosen from the inputs, in this priority: `enable`=0 gives `M_OFF`; otherwise `master`=0 gives `M_SLAVE`; otherwise `ext_mode`=1 gives `M_EXT`; otherwise `M_LOCK`. Any state can move to any other state this way, and a change takes effect one cycle after the inputs change.

A command-queue fill flag is raised whenever the command queue has room. Software clears it with a write-one-clear pulse. When the request enable is set, the flag is routed either to an interrupt or to a DMA request.

Top module: `cmd_push_front`

## Requirements
- R1: After reset both queues are empty with zero counts, the mode is `M_OFF`, `rd_data`, `fill_flag`, `fill_irq`, `fill_dma` and both pop valids are 0.
- R2: In `M_LOCK` a write with both `wr_cmd` and `wr_dat` set loads bits 31:16 into the command queue and the data half into the data queue in the same cycle. A write with only one strobe set changes neither queue.
- R3: In `M_LOCK` a push is accepted only when both queues have room. Otherwise neither queue is loaded, so the two counts stay aligned.
- R4: In `M_EXT` the command strobe and the data strobe each push their own queue independently.
- R5: With `wr_w8`=1 the data half is `wr_data[7:0]`, zero-extended to 16 bits.
- R6: While the block is enabled, `rd_data` is {command head, data head}. An empty queue contributes 0.
- R7: In `M_OFF` writes and pops leave both queues unchanged. `rd_data` returns the last halves written while enabled: the command half on any enabled command strobe outside `M_SLAVE`, and the data half on any enabled data strobe.
- R8: In `M_SLAVE` command writes are ignored and `cmd_pop_valid` is 0, while data pushes and pops still work.
- R9: A push into a full queue (count 4) is dropped and sets that queue's overflow flag. The flag is sticky until reset.
- R10: `fill_flag` becomes 1 one cycle after any cycle in which the command queue is not full. A `fill_clr` pulse clears it when the queue is full.
- R11: `fill_irq` = `fill_flag & fill_ie & !fill_sel`, and `fill_dma` = `fill_flag & fill_ie & fill_sel`.
- R12: Pops use valid/ready. In `M_LOCK` both valids are 1 only when both queues are non-empty, and both queues pop together only when both readies are 1.
- R13: A change on `enable`, `master` or `ext_mode` takes effect on the next cycle. A write in the same cycle is decoded in the old mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable |
| master | input | 1 | 1 = master, 0 = slave |
| ext_mode | input | 1 | 1 = independent pushes |
| wr_cmd | input | 1 | Write strobe, command half |
| wr_dat | input | 1 | Write strobe, data half |
| wr_w8 | input | 1 | Data write is 8 bits wide |
| wr_data | input | 32 | Push value {command, data} |
| rd_data | output | 32 | Push-port read value |
| cmd_pop_valid | output | 1 | Command head available |
| cmd_pop_ready | input | 1 | Shift engine takes command |
| cmd_pop_data | output | 16 | Command head |
| dat_pop_valid | output | 1 | Data head available |
| dat_pop_ready | input | 1 | Shift engine takes data |
| dat_pop_data | output | 16 | Data head |
| cmd_count | output | 3 | Command queue occupancy |
| dat_count | output | 3 | Data queue occupancy |
| cmd_full | output | 1 | Command queue full |
| dat_full | output | 1 | Data queue full |
| cmd_empty | output | 1 | Command queue empty |
| dat_empty | output | 1 | Data queue empty |
| cmd_ovf | output | 1 | Sticky command overflow |
| dat_ovf | output | 1 | Sticky data overflow |
| fill_clr | input | 1 | Write-one-clear of fill flag |
| fill_ie | input | 1 | Fill request enable |
| fill_sel | input | 1 | 0 = interrupt, 1 = DMA |
| fill_flag | output | 1 | Command-queue fill flag |
| fill_irq | output | 1 | Fill interrupt request |
| fill_dma | output | 1 | Fill DMA request |

## Verification
The bench first fills the data queue alone in extended mode and then attempts a lockstep push. A design that checked only the command queue for room would load a command with no matching data, and from then on would pair every command with the wrong data word. The bench also writes in the same cycle as a mode change, and writes while the block is off. A design that decoded the mode combinationally, or captured the read-back value while off, would show a changed count or the wrong read value. The fill flag is cleared while the queue is full, and routing is checked with the enable both off and on, which exposes an inverted select or an ungated request. A seeded random phase in extended mode compares counts and both heads against a bench-side queue model on every cycle.

// File: rtl/cpf_pkg.sv
package cpf_pkg;
    localparam int CPF_HALF_W = 16;
    localparam int CPF_DEPTH  = 4;

    typedef enum logic [1:0] {
        M_OFF   = 2'd0,
        M_LOCK  = 2'd1,
        M_EXT   = 2'd2,
        M_SLAVE = 2'd3
    } cpf_mode_e;
endpackage

// File: rtl/cpf_fifo.sv
module cpf_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 4,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          block,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty,
    output logic          ovf
);
    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic          do_wr, do_rd;

    assign full  = (count == CW'(DEPTH));
    assign empty = (count == '0);
    assign do_wr = push && !full && !block;
    assign do_rd = pop && !empty;
    assign head  = empty ? '0 : mem[rp];

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
            ovf   <= 1'b0;
        end else begin
            if (do_wr) wp <= nxt(wp);
            if (do_rd) rp <= nxt(rp);
            count <= count + CW'(do_wr) - CW'(do_rd);
            if (push && full) ovf <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_wr) mem[wp] <= din;
    end

    a_r9_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> ovf);
    a_r9_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !pop) |=> full);
endmodule

// File: rtl/cpf_mode_fsm.sv
module cpf_mode_fsm
    import cpf_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      enable,
    input  logic      master,
    input  logic      ext_mode,
    output cpf_mode_e st_q,
    output logic      is_lock,
    output logic      cmd_on,
    output logic      dat_on
);
    cpf_mode_e st_d;

    always_comb begin
        if (!enable)      st_d = M_OFF;
        else if (!master) st_d = M_SLAVE;
        else if (ext_mode) st_d = M_EXT;
        else              st_d = M_LOCK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= M_OFF;
        else        st_q <= st_d;
    end

    always_comb begin
        is_lock = 1'b0;
        cmd_on  = 1'b0;
        dat_on  = 1'b0;
        unique case (st_q)
            M_OFF:   ;
            M_LOCK:  begin is_lock = 1'b1; cmd_on = 1'b1; dat_on = 1'b1; end
            M_EXT:   begin cmd_on = 1'b1; dat_on = 1'b1; end
            M_SLAVE: dat_on = 1'b1;
            default: ;
        endcase
    end

    a_r13_off_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (st_q == M_OFF));
    a_r13_slave_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !master) |=> (st_q == M_SLAVE));
endmodule

// File: rtl/cpf_fill.sv
module cpf_fill (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_full,
    input  logic clr,
    input  logic ie,
    input  logic sel,
    output logic flag,
    output logic irq,
    output logic dma
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         flag <= 1'b0;
        else if (!cmd_full) flag <= 1'b1;
        else if (clr)       flag <= 1'b0;
    end

    assign irq = flag && ie && !sel;
    assign dma = flag && ie && sel;

    a_r10_fill_set: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_full |=> flag);
    a_r11_route_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq && dma));
    a_r11_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !ie |-> (!irq && !dma));
endmodule

// File: rtl/cmd_push_front.sv
module cmd_push_front
    import cpf_pkg::*;
#(
    parameter int HW    = CPF_HALF_W,
    parameter int DEPTH = CPF_DEPTH,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enable,
    input  logic            master,
    input  logic            ext_mode,
    input  logic            wr_cmd,
    input  logic            wr_dat,
    input  logic            wr_w8,
    input  logic [2*HW-1:0] wr_data,
    output logic [2*HW-1:0] rd_data,
    output logic            cmd_pop_valid,
    input  logic            cmd_pop_ready,
    output logic [HW-1:0]   cmd_pop_data,
    output logic            dat_pop_valid,
    input  logic            dat_pop_ready,
    output logic [HW-1:0]   dat_pop_data,
    output logic [CW-1:0]   cmd_count,
    output logic [CW-1:0]   dat_count,
    output logic            cmd_full,
    output logic            dat_full,
    output logic            cmd_empty,
    output logic            dat_empty,
    output logic            cmd_ovf,
    output logic            dat_ovf,
    input  logic            fill_clr,
    input  logic            fill_ie,
    input  logic            fill_sel,
    output logic            fill_flag,
    output logic            fill_irq,
    output logic            fill_dma
);
    cpf_mode_e       st_q;
    logic            is_lock, cmd_on, dat_on;
    logic [HW-1:0]   cmd_w, dat_w;
    logic            cmd_push, dat_push, blk, both, room;
    logic            cmd_pop, dat_pop;
    logic [2*HW-1:0] last_q;

    cpf_mode_fsm u_mode (
        .clk(clk), .rst_n(rst_n), .enable(enable), .master(master),
        .ext_mode(ext_mode), .st_q(st_q), .is_lock(is_lock),
        .cmd_on(cmd_on), .dat_on(dat_on)
    );

    assign cmd_w = wr_data[2*HW-1:HW];
    assign dat_w = wr_w8 ? {{(HW-8){1'b0}}, wr_data[7:0]} : wr_data[HW-1:0];
    assign both  = wr_cmd && wr_dat;
    assign room  = !cmd_full && !dat_full;

    always_comb begin
        cmd_push      = 1'b0;
        dat_push      = 1'b0;
        blk           = 1'b0;
        cmd_pop_valid = 1'b0;
        dat_pop_valid = 1'b0;
        cmd_pop       = 1'b0;
        dat_pop       = 1'b0;
        unique case (st_q)
            M_OFF: ;
            M_LOCK: begin
                cmd_push      = both;
                dat_push      = both;
                blk           = !room;
                cmd_pop_valid = !cmd_empty && !dat_empty;
                dat_pop_valid = cmd_pop_valid;
                cmd_pop       = cmd_pop_valid && cmd_pop_ready && dat_pop_ready;
                dat_pop       = cmd_pop;
            end
            M_EXT: begin
                cmd_push      = wr_cmd;
                dat_push      = wr_dat;
                cmd_pop_valid = !cmd_empty;
                dat_pop_valid = !dat_empty;
                cmd_pop       = cmd_pop_ready;
                dat_pop       = dat_pop_ready;
            end
            M_SLAVE: begin
                dat_push      = wr_dat;
                dat_pop_valid = !dat_empty;
                dat_pop       = dat_pop_ready;
            end
            default: ;
        endcase
    end

    cpf_fifo #(.W(HW), .DEPTH(DEPTH)) u_cmdq (
        .clk(clk), .rst_n(rst_n), .push(cmd_push), .block(blk), .din(cmd_w),
        .pop(cmd_pop), .head(cmd_pop_data), .count(cmd_count),
        .full(cmd_full), .empty(cmd_empty), .ovf(cmd_ovf)
    );

    cpf_fifo #(.W(HW), .DEPTH(DEPTH)) u_datq (
        .clk(clk), .rst_n(rst_n), .push(dat_push), .block(blk), .din(dat_w),
        .pop(dat_pop), .head(dat_pop_data), .count(dat_count),
        .full(dat_full), .empty(dat_empty), .ovf(dat_ovf)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_q <= '0;
        end else begin
            if (cmd_on && wr_cmd) last_q[2*HW-1:HW] <= cmd_w;
            if (dat_on && wr_dat) last_q[HW-1:0]    <= dat_w;
        end
    end

    assign rd_data = (st_q == M_OFF) ? last_q : {cmd_pop_data, dat_pop_data};

    cpf_fill u_fill (
        .clk(clk), .rst_n(rst_n), .cmd_full(cmd_full), .clr(fill_clr),
        .ie(fill_ie), .sel(fill_sel), .flag(fill_flag),
        .irq(fill_irq), .dma(fill_dma)
    );

    a_r7_off_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == M_OFF) |=> ($stable(cmd_count) && $stable(dat_count)));
    a_r8_slave_cmd_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == M_SLAVE) |=> $stable(cmd_count));
    a_r3_lock_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == M_LOCK && cmd_count == dat_count) |=> (cmd_count == dat_count));
endmodule

// File: tb/cmd_push_front_tb_top.sv
module cmd_push_front_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 0, master = 0, ext_mode = 0;
    logic        wr_cmd = 0, wr_dat = 0, wr_w8 = 0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        cmd_pop_valid, dat_pop_valid;
    logic        cmd_pop_ready = 0, dat_pop_ready = 0;
    logic [15:0] cmd_pop_data, dat_pop_data;
    logic [2:0]  cmd_count, dat_count;
    logic        cmd_full, dat_full, cmd_empty, dat_empty, cmd_ovf, dat_ovf;
    logic        fill_clr = 0, fill_ie = 0, fill_sel = 0;
    logic        fill_flag, fill_irq, fill_dma;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    cmd_push_front dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .master(master),
        .ext_mode(ext_mode), .wr_cmd(wr_cmd), .wr_dat(wr_dat), .wr_w8(wr_w8),
        .wr_data(wr_data), .rd_data(rd_data),
        .cmd_pop_valid(cmd_pop_valid), .cmd_pop_ready(cmd_pop_ready),
        .cmd_pop_data(cmd_pop_data), .dat_pop_valid(dat_pop_valid),
        .dat_pop_ready(dat_pop_ready), .dat_pop_data(dat_pop_data),
        .cmd_count(cmd_count), .dat_count(dat_count),
        .cmd_full(cmd_full), .dat_full(dat_full),
        .cmd_empty(cmd_empty), .dat_empty(dat_empty),
        .cmd_ovf(cmd_ovf), .dat_ovf(dat_ovf),
        .fill_clr(fill_clr), .fill_ie(fill_ie), .fill_sel(fill_sel),
        .fill_flag(fill_flag), .fill_irq(fill_irq), .fill_dma(fill_dma)
    );

    always #4 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        wr_cmd = 0; wr_dat = 0; wr_w8 = 0;
        cmd_pop_ready = 0; dat_pop_ready = 0; fill_clr = 0;
    endtask

    task automatic wr(input logic c, input logic d, input logic w8, input logic [31:0] v);
        wr_cmd = c; wr_dat = d; wr_w8 = w8; wr_data = v;
        cyc();
        idle();
    endtask

    function automatic logic [31:0] exp_rd(input logic [15:0] qc[$], input logic [15:0] qd[$]);
        logic [15:0] c, d;
        c = (qc.size() > 0) ? qc[0] : 16'h0;
        d = (qd.size() > 0) ? qd[0] : 16'h0;
        return {c, d};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] qc[$];
        logic [15:0] qd[$];
        logic [31:0] v;
        logic c, d, w8, rc, rd;
        int seed;
        seed = 17;
        void'($urandom(seed));

        cyc(); cyc();
        rst_n = 1; #1;
        // R1 reset state
        check("R1 counts", {26'h0, cmd_count, dat_count}, 32'h0);
        check("R1 rd_data", rd_data, 32'h0);
        check("R1 flags", {28'h0, fill_flag, fill_irq, fill_dma, cmd_pop_valid}, 32'h0);

        // R13: write in the same cycle the mode switches is decoded as M_OFF
        enable = 1; master = 1; ext_mode = 0;
        wr(1, 1, 0, 32'h1111_2222);
        check("R13 write in old mode ignored", {26'h0, cmd_count, dat_count}, 32'h0);
        check("R13 rd_data now live", rd_data, 32'h0);

        // R2 lockstep push
        wr(1, 1, 0, 32'h1111_2222);
        check("R2 lock counts", {26'h0, cmd_count, dat_count}, {26'h0, 3'd1, 3'd1});
        check("R6 rd heads", rd_data, 32'h1111_2222);
        wr(1, 0, 0, 32'h3333_4444);
        check("R2 single strobe ignored", {26'h0, cmd_count, dat_count}, {26'h0, 3'd1, 3'd1});
        // R5 8-bit write
        wr(1, 1, 1, 32'h5555_ABCD);
        check("R2 second push", {26'h0, cmd_count, dat_count}, {26'h0, 3'd2, 3'd2});

        // R12 lockstep pop needs both readies
        cmd_pop_ready = 1; #1;
        check("R12 lock valid", {30'h0, cmd_pop_valid, dat_pop_valid}, 32'h3);
        check("R12 head data", {cmd_pop_data, dat_pop_data}, 32'h1111_2222);
        cyc();
        check("R12 one ready no pop", {26'h0, cmd_count, dat_count}, {26'h0, 3'd2, 3'd2});
        dat_pop_ready = 1;
        cyc(); idle();
        check("R12 joint pop", {26'h0, cmd_count, dat_count}, {26'h0, 3'd1, 3'd1});
        check("R5 zero-extended byte", rd_data, 32'h5555_00CD);

        // R4/R9 independent data pushes up to full, then overflow
        ext_mode = 1; cyc();
        wr(0, 1, 0, 32'h0000_0D01);
        wr(0, 1, 0, 32'h0000_0D02);
        wr(0, 1, 0, 32'h0000_0D03);
        check("R4 data only", {26'h0, cmd_count, dat_count}, {26'h0, 3'd1, 3'd4});
        wr(0, 1, 0, 32'h0000_0D04);
        check("R9 full drop", {29'h0, dat_count}, 32'd4);
        check("R9 overflow set", {30'h0, dat_ovf, cmd_ovf}, 32'h2);
        // R3 lockstep rejected when data full
        ext_mode = 0; cyc();
        wr(1, 1, 0, 32'h7777_8888);
        check("R3 lock reject", {26'h0, cmd_count, dat_count}, {26'h0, 3'd1, 3'd4});
        check("R3 no cmd ovf", {31'h0, cmd_ovf}, 32'h0);
        check("R3 heads unchanged", rd_data, 32'h5555_00CD);

        // R10 fill flag
        ext_mode = 1; cyc();
        check("R10 flag while room", {31'h0, fill_flag}, 32'h1);
        wr(1, 0, 0, 32'hC001_0000);
        wr(1, 0, 0, 32'hC002_0000);
        wr(1, 0, 0, 32'hC003_0000);
        check("R4 cmd only", {26'h0, cmd_count, dat_count}, {26'h0, 3'd4, 3'd4});
        fill_clr = 1; cyc(); idle();
        check("R10 clear when full", {31'h0, fill_flag}, 32'h0);
        fill_ie = 1; fill_sel = 0; cyc();
        check("R10 stays clear", {31'h0, fill_flag}, 32'h0);
        check("R11 no request without flag", {30'h0, fill_irq, fill_dma}, 32'h0);
        cmd_pop_ready = 1; cyc(); idle();
        cyc();
        check("R10 flag re-set", {31'h0, fill_flag}, 32'h1);
        check("R11 irq route", {30'h0, fill_irq, fill_dma}, 32'h2);
        fill_sel = 1; #1;
        check("R11 dma route", {30'h0, fill_irq, fill_dma}, 32'h1);
        fill_ie = 0; #1;
        check("R11 disabled", {30'h0, fill_irq, fill_dma}, 32'h0);

        // R7 disabled
        enable = 0; cyc();
        wr(1, 1, 0, 32'h9999_9999);
        check("R7 counts frozen", {26'h0, cmd_count, dat_count}, {26'h0, 3'd3, 3'd4});
        check("R7 last enabled write", rd_data, 32'hC003_8888);
        dat_pop_ready = 1; #1;
        check("R7 no pop valid", {30'h0, cmd_pop_valid, dat_pop_valid}, 32'h0);
        cyc(); idle();
        check("R7 pop ignored", {29'h0, dat_count}, 32'd4);

        // R8 slave
        enable = 1; master = 0; cyc();
        check("R8 no cmd valid", {30'h0, cmd_pop_valid, dat_pop_valid}, 32'h1);
        dat_pop_ready = 1; cyc(); idle();
        wr(1, 1, 0, 32'hAAAA_BBBB);
        check("R8 cmd ignored data taken", {26'h0, cmd_count, dat_count}, {26'h0, 3'd3, 3'd4});

        // random extended phase against a queue model
        rst_n = 0; enable = 1; master = 1; ext_mode = 1; cyc();
        rst_n = 1; cyc();
        for (int i = 0; i < 400; i++) begin
            c  = ($urandom % 3) != 0;
            d  = ($urandom % 3) != 0;
            w8 = $urandom % 2;
            rc = ($urandom % 2);
            rd = ($urandom % 2);
            v  = $urandom;
            wr_cmd = c; wr_dat = d; wr_w8 = w8; wr_data = v;
            cmd_pop_ready = rc; dat_pop_ready = rd;
            if (rc && qc.size() > 0) void'(qc.pop_front());
            if (rd && qd.size() > 0) void'(qd.pop_front());
            if (c && (qc.size() + ((rc && qc.size() > 0) ? 1 : 0)) < 4) qc.push_back(v[31:16]);
            if (d && (qd.size() + ((rd && qd.size() > 0) ? 1 : 0)) < 4)
                qd.push_back(w8 ? {8'h0, v[7:0]} : v[15:0]);
            cyc();
            check("R4 random counts", {26'h0, cmd_count, dat_count},
                  {26'h0, 3'(qc.size()), 3'(qd.size())});
            check("R6 random heads", rd_data, exp_rd(qc, qd));
        end
        idle();

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule